// File: doc/BRIEF.md
# Serial Port Address Decoder with Programmable Slave Settings

This block sits behind the bit-level front ends of three two-wire serial ports: one control port and two bank ports (port A, port B). Once a front end has shifted in the first byte after a start condition, it presents that byte together with the port number. One clock later the block returns a decision. The decision says whether to acknowledge the byte, whether a read or a write may follow, whether the target is the settings file or a storage bank, and which bank. When it declines, it tells the front end to drop back to idle and wait for the next start condition.

The block also holds the 16-byte settings file that controls these decisions. For each port the file stores a slave address, an enable for that address, and a two-bit access level. Settings are loaded through a plain write strobe and can be read back combinationally. The control port can additionally pick a bank through one bit of its address byte. It can also reach the settings file through a fixed address that no access level can lock out.

The request side carries no ready signal. The block accepts one address byte on every cycle in which `in_valid` is high, so it never applies back-pressure. Each accepted byte produces exactly one decision, marked by `dec_valid`, on the following cycle.

Top module: `addr_guard`

## Requirements
- R1: A byte whose bits [7:4] are not 1010b is never acknowledged for bank access. Bit 0 of the address byte is the direction: 1 means read and 0 means write.
- R2: Port A and port B compare address-byte bits [3:1] with slave bits [6:4] of their settings word. The control port compares byte bits [3:2] with settings bits [6:5]. Port number 0 is the control port, 1 is port A, 2 is port B, and 3 never matches.
- R3: On an acknowledged bank access, `dec_bank` equals byte bit 1 for the control port, 0 for port A and 1 for port B.
- R4: When a port's enable bit (settings bit 7) is 0, its slave bits are ignored in the comparison.
- R5: Byte bits [7:1] equal to 1011100b on the control port are always acknowledged with `dec_cfg` set and `dec_bank` low. A read proceeds if bit 0 is 1 and a write proceeds if bit 0 is 0, whatever the access level. The same byte on port A or port B is not acknowledged.
- R6: Access level 00 (settings bits [1:0]) gives no acknowledge and no operation.
- R7: Access level 01 acknowledges but lets neither a read nor a write proceed.
- R8: Access level 10 acknowledges and lets only reads proceed.
- R9: Access level 11 acknowledges and lets both reads and writes proceed.
- R10: After reset, settings locations 0, 1 and 2 (control port, port A, port B) read 0x83: slave bits 000, enable 1, level 11. Locations 3 to 14 read 0.
- R11: Location 15 always reads the parameter `REV`, and writes to it are ignored.
- R12: Locations 3 to 14 store and return any written byte and have no effect on decoding.
- R13: Each `in_valid` cycle yields exactly one `dec_valid` cycle one clock later. `dec_drop` is high exactly when `dec_ack` is low, and without an acknowledge all other decision flags are low.
- R14: A decode and a settings write in the same cycle use the settings as they were before that write. The new value governs from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address byte present this cycle |
| in_port | input | 2 | Source port: 0 control, 1 port A, 2 port B |
| in_byte | input | 8 | Address byte: [7:1] device address, [0] direction |
| dec_valid | output | 1 | Decision valid |
| dec_ack | output | 1 | Acknowledge the address byte |
| dec_rd | output | 1 | Read may proceed |
| dec_wr | output | 1 | Write may proceed |
| dec_cfg | output | 1 | Target is the settings file |
| dec_bank | output | 1 | Target bank: 0 first, 1 second |
| dec_drop | output | 1 | Return to idle and wait for a start condition |
| cfg_we | input | 1 | Settings write strobe |
| cfg_waddr | input | 4 | Settings write location |
| cfg_wdata | input | 8 | Settings write data |
| cfg_raddr | input | 4 | Settings read location |
| cfg_rdata | output | 8 | Settings read data (combinational) |

## Verification
A settings write and an address decode can land in the same clock, and a changed access level or slave address then competes with the decision being formed. The bench provokes this by holding a decode on port A in the same cycle as a write that lowers port A's level from 11 to 00. It expects an acknowledge for that byte, because the old settings still apply. A second decode of the same byte one cycle later must then be refused. Around this, the bench sweeps every address byte on every port under several settings patterns and compares each decision with an arithmetic model.

// File: rtl/addr_guard_pkg.sv
package addr_guard_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam logic [6:0] CFG_DEV  = 7'b1011100;
  localparam logic [1:0] PORT_CTRL = 2'd0;
  localparam logic [1:0] PORT_A    = 2'd1;
  localparam logic [1:0] PORT_B    = 2'd2;
  localparam logic [7:0] SET_RESET = 8'h83;

  typedef struct packed {
    logic ack;
    logic rd;
    logic wr;
    logic cfg;
    logic bank;
    logic drop;
  } decision_t;
endpackage

// File: rtl/guard_cfg_file.sv
module guard_cfg_file #(
  parameter int DATA_W = 8,
  parameter int LOC_N = 16,
  parameter int PORT_N = 3,
  parameter logic [DATA_W-1:0] REV = 8'h5A,
  localparam int ADDR_W = $clog2(LOC_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] port_set [PORT_N]
);
  import addr_guard_pkg::*;
  logic [DATA_W-1:0] loc [LOC_N];

  for (genvar i = 0; i < LOC_N; i++) begin : g_loc
    if (i == LOC_N - 1) begin : g_rev
      assign loc[i] = REV;
    end else begin : g_store
      localparam logic [DATA_W-1:0] INIT = (i < PORT_N) ? SET_RESET : '0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) loc[i] <= INIT;
        else if (we && waddr == ADDR_W'(i)) loc[i] <= wdata;
      end
    end
  end

  for (genvar p = 0; p < PORT_N; p++) begin : g_port
    assign port_set[p] = loc[p];
  end

  assign rdata = loc[raddr];
endmodule

// File: rtl/guard_match.sv
module guard_match (
  input  logic [1:0] port,
  input  logic [7:0] abyte,
  input  logic       sl_en,
  input  logic [2:0] sl_bits,
  input  logic [1:0] level,
  output addr_guard_pkg::decision_t dec
);
  import addr_guard_pkg::*;
  logic is_cfg, code_ok, slave_ok, bank_hit, rw;

  always_comb begin
    rw      = abyte[0];
    is_cfg  = (port == PORT_CTRL) && (abyte[7:1] == CFG_DEV);
    code_ok = (abyte[7:4] == DEV_CODE);
    unique case (port)
      PORT_CTRL:      slave_ok = !sl_en || (abyte[3:2] == sl_bits[2:1]);
      PORT_A, PORT_B: slave_ok = !sl_en || (abyte[3:1] == sl_bits);
      default:        slave_ok = 1'b0;
    endcase
    bank_hit = code_ok && slave_ok && (level != 2'b00);
    dec = '0;
    if (is_cfg) begin
      dec.ack = 1'b1;
      dec.cfg = 1'b1;
      dec.rd  = rw;
      dec.wr  = !rw;
    end else if (bank_hit) begin
      dec.ack  = 1'b1;
      dec.rd   = rw && level[1];
      dec.wr   = !rw && (level == 2'b11);
      dec.bank = (port == PORT_CTRL) ? abyte[1] : (port == PORT_B);
    end
    dec.drop = !dec.ack;
  end
endmodule

// File: rtl/addr_guard.sv
module addr_guard #(
  parameter int DATA_W = 8,
  parameter int LOC_N = 16,
  parameter logic [7:0] REV = 8'h5A,
  localparam int ADDR_W = $clog2(LOC_N),
  localparam int PORT_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_port,
  input  logic [7:0]        in_byte,
  output logic              dec_valid,
  output logic              dec_ack,
  output logic              dec_rd,
  output logic              dec_wr,
  output logic              dec_cfg,
  output logic              dec_bank,
  output logic              dec_drop,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_waddr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] cfg_raddr,
  output logic [DATA_W-1:0] cfg_rdata
);
  import addr_guard_pkg::*;
  logic [DATA_W-1:0] port_set [PORT_N];
  logic [7:0] sel_set;
  decision_t dec_c, dec_q;
  logic valid_q;

  guard_cfg_file #(.DATA_W(DATA_W), .LOC_N(LOC_N), .PORT_N(PORT_N), .REV(REV)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
    .raddr(cfg_raddr), .rdata(cfg_rdata), .port_set(port_set)
  );

  always_comb begin
    sel_set = '0;
    if (in_port < 2'(PORT_N)) sel_set = port_set[in_port][7:0];
  end

  guard_match u_match (
    .port(in_port), .abyte(in_byte), .sl_en(sel_set[7]), .sl_bits(sel_set[6:4]),
    .level(sel_set[1:0]), .dec(dec_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      dec_q   <= '0;
    end else begin
      valid_q <= in_valid;
      dec_q   <= in_valid ? dec_c : '0;
    end
  end

  assign dec_valid = valid_q;
  assign dec_ack   = dec_q.ack;
  assign dec_rd    = dec_q.rd;
  assign dec_wr    = dec_q.wr;
  assign dec_cfg   = dec_q.cfg;
  assign dec_bank  = dec_q.bank;
  assign dec_drop  = valid_q && dec_q.drop;
endmodule

// File: rtl/addr_guard_chk.sv
module addr_guard_chk #(
  parameter logic [7:0] REV = 8'h5A
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] in_port,
  input logic [7:0] in_byte,
  input logic       dec_valid,
  input logic       dec_ack,
  input logic       dec_rd,
  input logic       dec_wr,
  input logic       dec_cfg,
  input logic       dec_bank,
  input logic       dec_drop,
  input logic [3:0] cfg_raddr,
  input logic [7:0] cfg_rdata
);
  assert_one_decision_R13: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> dec_valid);
  assert_no_spurious_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !dec_valid && !dec_ack);
  assert_drop_clean_R13: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ack |-> dec_drop && !dec_rd && !dec_wr && !dec_cfg);
  assert_dir_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_byte[0] |=> !dec_wr);
  assert_dir_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_byte[0] |=> !dec_rd);
  assert_cfg_ctrl_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_port != 2'd0 |=> !dec_cfg);
  assert_cfg_always_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_port == 2'd0 && in_byte[7:1] == 7'b1011100 |=> dec_ack && dec_cfg && !dec_bank);
  assert_bank_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_port == 2'd1 |=> !dec_bank);
  assert_rev_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_raddr == 4'hF |-> cfg_rdata == REV);
endmodule

bind addr_guard addr_guard_chk #(.REV(REV)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port), .in_byte(in_byte),
  .dec_valid(dec_valid), .dec_ack(dec_ack), .dec_rd(dec_rd), .dec_wr(dec_wr),
  .dec_cfg(dec_cfg), .dec_bank(dec_bank), .dec_drop(dec_drop),
  .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata)
);

// File: tb/addr_guard_tb.sv
`timescale 1ns/1ps
module addr_guard_tb;
  localparam logic [7:0] REV = 8'h5A;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic [1:0] in_port = 0;
  logic [7:0] in_byte = 0;
  logic dec_valid, dec_ack, dec_rd, dec_wr, dec_cfg, dec_bank, dec_drop;
  logic cfg_we = 0;
  logic [3:0] cfg_waddr = 0, cfg_raddr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  int checks = 0, fails = 0;
  logic [7:0] mdl [16];

  always #2.5 clk = ~clk;

  addr_guard #(.REV(REV)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port), .in_byte(in_byte),
    .dec_valid(dec_valid), .dec_ack(dec_ack), .dec_rd(dec_rd), .dec_wr(dec_wr),
    .dec_cfg(dec_cfg), .dec_bank(dec_bank), .dec_drop(dec_drop),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata)
  );

  // expected {valid, ack, rd, wr, cfg, bank, drop}
  function automatic logic [6:0] expect_dec(input logic [1:0] p, input logic [7:0] b,
                                            input logic [7:0] s);
    logic ack, rd, wr, cfg, bank, hit;
    ack = 0; rd = 0; wr = 0; cfg = 0; bank = 0;
    if (p == 0 && b[7:1] == 7'h5C) begin
      ack = 1; cfg = 1; rd = b[0]; wr = !b[0];
    end else if (p != 3) begin
      hit = (b[7:4] == 4'hA) && (s[1:0] != 0);
      if (s[7]) hit = hit && ((p == 0) ? (b[3:2] == s[6:5]) : (b[3:1] == s[6:4]));
      if (hit) begin
        ack = 1; rd = b[0] && s[1]; wr = !b[0] && (s[1:0] == 3);
        bank = (p == 0) ? b[1] : (p == 2);
      end
    end
    return {1'b1, ack, rd, wr, cfg, bank, !ack};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a != 4'hF) mdl[a] = d;
  endtask

  task automatic decode(input string req, input logic [1:0] p, input logic [7:0] b);
    logic [6:0] e;
    e = expect_dec(p, b, (p == 3) ? 8'h00 : mdl[p]);
    @(negedge clk);
    in_valid = 1; in_port = p; in_byte = b;
    @(negedge clk);
    in_valid = 0;
    check(req, {dec_valid, dec_ack, dec_rd, dec_wr, dec_cfg, dec_bank, dec_drop}, e);
  endtask

  function automatic string req_of(input logic [1:0] p, input logic [7:0] b,
                                   input logic [7:0] s);
    if (p == 0 && b[7:1] == 7'h5C) return "R5";
    if (b[7:4] != 4'hA) return "R1";
    if (!s[7]) return "R4";
    case (s[1:0])
      2'd0: return "R6";
      2'd1: return "R7";
      2'd2: return "R8";
      default: return "R2 R3 R9 R13";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = (i < 3) ? 8'h83 : 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 / R11 reset contents
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); cfg_raddr = 4'(i); #1;
      check(i == 15 ? "R11" : "R10", cfg_rdata, (i == 15) ? REV : mdl[i]);
    end
    check("R13", {dec_valid, dec_ack, dec_drop}, 3'b000);
    // R12 storage, R11 write ignored
    for (int i = 3; i < 16; i++) cfg_write(4'(i), 8'(i * 37 + 5));
    for (int i = 3; i < 16; i++) begin
      @(negedge clk); cfg_raddr = 4'(i); #1;
      check(i == 15 ? "R11" : "R12", cfg_rdata, (i == 15) ? REV : 8'(i * 37 + 5));
    end
    // sweeps: reset settings first, then patterns
    for (int k = -1; k < 6; k++) begin
      if (k >= 0)
        for (int p = 0; p < 3; p++)
          cfg_write(4'(p), {(k != 1), 3'((k * 3 + p) % 8), 2'b00, 2'((k + p) % 4)});
      for (int p = 0; p < 4; p++)
        for (int b = 0; b < 256; b++)
          decode(req_of(2'(p), 8'(b), (p == 3) ? 8'h00 : mdl[p]), 2'(p), 8'(b));
    end
    // R14: same-cycle write and decode on port A
    cfg_write(4'd1, 8'h03);
    @(negedge clk);
    in_valid = 1; in_port = 1; in_byte = 8'hA1;
    cfg_we = 1; cfg_waddr = 4'd1; cfg_wdata = 8'h00;
    @(negedge clk);
    in_valid = 0; cfg_we = 0; mdl[1] = 8'h00;
    check("R14", {dec_valid, dec_ack, dec_rd, dec_drop}, 4'b1110);
    decode("R14", 2'd1, 8'hA1);
    check("R14", {dec_ack, dec_drop}, 2'b01);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule